// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of one frequency-synthesizer loop. It is clocked by the output of an external dual-modulus prescaler. It holds a 6-bit swallow count and an 11-bit main count. While the swallow count is nonzero, it asks the prescaler for the larger modulus (P+1). After that it asks for the smaller one (P). Each time the main count runs out, it emits a single-cycle pulse toward the phase detector. One full output period therefore spans `main_in` prescaler cycles, which is P*B + A cycles of the prescaler input.

A select bit chooses between two prescaler pairs, 8/9 and 16/17. The chosen pair is handed to the prescaler on `pair_sel`. New swallow, main and pair values are captured only when the counters reload, so a period already under way is never disturbed. A counter-reset input and a power-down input each hold the divider in its load state. When both are released, counting restarts on the very next prescaler cycle, keeping the divider aligned with the reference divider. A setting whose main value is zero or smaller than its swallow value is flagged as invalid, and the divider stays in its load state until a valid setting is applied.

Top module: `swallow_fb_divider`

## Requirements
- R1: While `rst` is high, `mod_hi` and `div_pulse` are 0.
- R2: With a valid setting of main value B, `div_pulse` is high for exactly one cycle in every B prescaler cycles: on the last cycle (index B-1) of each period, where index 0 is the first cycle after the load state ends.
- R3: With swallow value A, `mod_hi` is 1 on period cycles 0 to A-1 and 0 on the remaining cycles of the period.
- R4: `pair_sel` shows the select bit of the active setting. The prescaler modulus P is 8 when it is 0 and 16 when it is 1. The prescaler input cycles per period, (P+1) times the `mod_hi` cycles plus P times the other cycles, equal P*B + A.
- R5: While `cnt_rst` is high, `mod_hi` and `div_pulse` are 0 and the inputs are captured. The first cycle after it falls is period cycle 0.
- R6: While `pwr_dn` is high, the divider behaves as under R5. The first cycle after it falls is period cycle 0.
- R7: A setting with B = 0 or B < A drives `cfg_bad` to 1 and holds `mod_hi` and `div_pulse` at 0. A valid setting applied later starts a period on the next cycle.
- R8: A change of `swal_in`, `main_in` or `psel_in` during a period takes effect only at the next reload. The current period keeps its old length, `mod_hi` pattern and `pair_sel`.
- R9: B = 1 gives a pulse on every cycle. A = 0 keeps `mod_hi` at 0. A = B keeps `mod_hi` at 1 for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_rst | input | 1 | Counter reset: holds the divider in its load state |
| pwr_dn | input | 1 | Power-down: holds the divider in its load state |
| swal_in | input | 6 | Swallow value A |
| main_in | input | 11 | Main value B |
| psel_in | input | 1 | Prescaler pair select (0: 8/9, 1: 16/17) |
| mod_hi | output | 1 | Request for the larger modulus P+1 |
| div_pulse | output | 1 | Single-cycle divided output pulse |
| pair_sel | output | 1 | Pair select of the active setting |
| cfg_bad | output | 1 | Active setting is invalid |

## Verification
The hardest situations to reach are a setting change that lands part-way through a period, and an invalid setting that is captured at a reload boundary while the divider is running. Both need inputs to change on an exact cycle offset relative to the pulse. The bench counts cycles from the release of the load state and drives the new values on chosen offsets. It then checks that the old period finishes untouched, that the new period follows, and that the divider goes quiet from the boundary and restarts once the setting is fixed. A sweep over every small A and B value, for both prescaler pairs, released alternately by counter reset and by power-down, covers the arithmetic and the edge cases.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
    localparam int SWAL_W = 6;
    localparam int MAIN_W = 11;

    typedef struct packed {
        logic              psel;
        logic [SWAL_W-1:0] swal;
        logic [MAIN_W-1:0] mainv;
    } div_cfg_t;

    // A setting is usable when the main count is nonzero and covers the swallow count
    function automatic logic cfg_usable(div_cfg_t c);
        return (c.mainv != '0) && (c.mainv >= MAIN_W'(c.swal));
    endfunction
endpackage

// File: rtl/swal_counter.sv
module swal_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] ld_val,
    output logic         hi_req
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load)
            cnt <= ld_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign hi_req = run && (cnt != '0);

    AST_SWALLOW_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3
    AST_SWALLOW_PARK: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0)); // R3
endmodule

// File: rtl/main_counter.sv
module main_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] ld_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load)
            cnt <= ld_val;
        else if (run)
            cnt <= cnt - 1'b1;
    end

    assign expire = run && (cnt == W'(1));

    AST_MAIN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(ld_val))); // R2
    AST_MAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && run) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
    import swallow_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_rst,
    input  logic              pwr_dn,
    input  logic [SWAL_W-1:0] swal_in,
    input  logic [MAIN_W-1:0] main_in,
    input  logic              psel_in,
    output logic              mod_hi,
    output logic              div_pulse,
    output logic              pair_sel,
    output logic              cfg_bad
);
    div_cfg_t cfg_in, cfg_act;
    logic     hold, run, reload, expire;

    assign cfg_in = '{psel: psel_in, swal: swal_in, mainv: main_in};
    assign hold   = rst || cnt_rst || pwr_dn;
    assign cfg_bad = !cfg_usable(cfg_act);
    assign run    = !hold && !cfg_bad;
    assign reload = hold || cfg_bad || expire;

    // Active setting: captured only at a reload boundary or in the load state
    always_ff @(posedge clk) begin
        if (reload)
            cfg_act <= cfg_in;
    end

    swal_counter #(.W(SWAL_W)) u_swal (
        .clk(clk), .rst(rst), .load(reload), .run(run),
        .ld_val(cfg_in.swal), .hi_req(mod_hi)
    );

    main_counter #(.W(MAIN_W)) u_main (
        .clk(clk), .rst(rst), .load(reload), .run(run),
        .ld_val(cfg_in.mainv), .expire(expire)
    );

    assign div_pulse = expire;
    assign pair_sel  = cfg_act.psel;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !reload |=> (cfg_act == $past(cfg_act))); // R8
    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> (!mod_hi && !div_pulse)); // R7
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cnt_rst || pwr_dn) |-> (!mod_hi && !div_pulse)); // R5
    AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && !hold) |=> (cfg_act == $past(cfg_in))); // R2
endmodule

// File: tb/tb_swallow_fb_divider.sv
`timescale 1ns/1ps
module tb_swallow_fb_divider;
    logic        clk = 0;
    logic        rst, cnt_rst, pwr_dn, psel_in;
    logic [5:0]  swal_in;
    logic [10:0] main_in;
    logic        mod_hi, div_pulse, pair_sel, cfg_bad;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    swallow_fb_divider dut (
        .clk(clk), .rst(rst), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
        .swal_in(swal_in), .main_in(main_in), .psel_in(psel_in),
        .mod_hi(mod_hi), .div_pulse(div_pulse), .pair_sel(pair_sel), .cfg_bad(cfg_bad)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setcfg(input int ps, input int a, input int b);
        psel_in = ps[0]; swal_in = 6'(a); main_in = 11'(b);
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // Hold, release, then compare every cycle against the arithmetic model
    task automatic run_cfg(input int ps, input int a, input int b, input bit use_pd);
        int bad_out = 0, hi = 0, lo = 0, pmod, held_bad = 0;
        bit valid = (b != 0) && (b >= a);
        int len = valid ? 3 * b : 8;
        @(negedge clk);
        setcfg(ps, a, b);
        if (use_pd) pwr_dn = 1; else cnt_rst = 1;
        #1;
        for (int i = 0; i < 2; i++) begin
            if (mod_hi || div_pulse) held_bad++;
            tick();
        end
        check(use_pd ? "R6 hold quiet" : "R5 hold quiet", held_bad, 0);
        @(negedge clk);
        pwr_dn = 0; cnt_rst = 0;
        #1;
        pmod = ps ? 16 : 8;
        for (int c = 0; c < len; c++) begin
            int ph = valid ? c % b : 0;
            int ep = valid && (ph == b - 1);
            int em = valid && (ph < a);
            if (div_pulse != ep[0] || mod_hi != em[0]) bad_out++;
            if (valid && c < b) begin
                if (mod_hi) hi++; else lo++;
            end
            tick();
        end
        if (valid) begin
            check($sformatf("R2 R3 R9 pattern ps=%0d a=%0d b=%0d", ps, a, b), bad_out, 0);
            check($sformatf("R4 ratio ps=%0d a=%0d b=%0d", ps, a, b),
                  (pmod + 1) * hi + pmod * lo, pmod * b + a);
            check("R4 pair_sel", int'(pair_sel), ps);
        end else begin
            check($sformatf("R7 quiet a=%0d b=%0d", a, b), bad_out, 0);
            check("R7 cfg_bad", int'(cfg_bad), 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int errs;
        rst = 1; cnt_rst = 0; pwr_dn = 0;
        setcfg(0, 2, 5);
        tick(); tick();
        check("R1 mod_hi in reset", int'(mod_hi), 0);
        check("R1 div_pulse in reset", int'(div_pulse), 0);
        @(negedge clk); rst = 0; #1;

        // Sweep all small settings, both pairs, alternating release source
        for (int ps = 0; ps < 2; ps++)
            for (int a = 0; a < 6; a++)
                for (int b = 0; b < 7; b++)
                    run_cfg(ps, a, b, bit'((a + b) % 2));

        // R8: mid-period change; old A=2,B=5,ps=0 then new A=1,B=3,ps=1
        run_cfg(0, 2, 5, 0);
        @(negedge clk); cnt_rst = 1; #1; tick();
        @(negedge clk); cnt_rst = 0; #1;
        errs = 0;
        for (int c = 0; c < 11; c++) begin
            int ep, em, es;
            if (c == 1) setcfg(1, 1, 3);
            ep = (c == 4) || (c == 7) || (c == 10);
            em = (c < 2) || (c == 5) || (c == 8);
            es = (c >= 5);
            if (div_pulse != ep[0] || mod_hi != em[0] || pair_sel != es[0]) begin
                errs++;
                $display("FAIL R8 cycle %0d: actual p=%0d m=%0d s=%0d expected p=%0d m=%0d s=%0d",
                         c, div_pulse, mod_hi, pair_sel, ep, em, es);
            end
            tick();
        end
        check("R8 change at boundary", errs, 0);

        // R7: invalid setting captured at a boundary, then fixed
        @(negedge clk); setcfg(0, 1, 3); cnt_rst = 1; #1; tick();
        @(negedge clk); cnt_rst = 0; setcfg(0, 4, 2); #1;
        check("R7 old period pulse absent c0", int'(div_pulse), 0);
        tick(); tick();
        check("R7 old period ends with pulse", int'(div_pulse), 1);
        tick();
        check("R7 cfg_bad after boundary", int'(cfg_bad), 1);
        errs = 0;
        for (int c = 0; c < 6; c++) begin
            if (div_pulse || mod_hi) errs++;
            tick();
        end
        check("R7 quiet while invalid", errs, 0);
        @(negedge clk); setcfg(0, 1, 2); #1;
        tick();
        check("R7 restart mod_hi cycle0", int'(mod_hi), 1);
        check("R7 restart no pulse cycle0", int'(div_pulse), 0);
        tick();
        check("R7 restart pulse cycle1", int'(div_pulse), 1);

        // R6: power-down in mid period, then aligned restart
        @(negedge clk); pwr_dn = 1; #1;
        check("R6 pd quiet", int'(mod_hi | div_pulse), 0);
        tick();
        @(negedge clk); pwr_dn = 0; #1;
        check("R6 restart mod_hi", int'(mod_hi), 1);
        tick();
        check("R6 restart pulse", int'(div_pulse), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule